// File: doc/BRIEF.md
# Bidirectional 16-to-40-bit Shifter

This block shifts a 16-bit two's-complement word into a 40-bit result register. The shift amount is a signed 8-bit code. A positive code moves the data toward bit 39 and a negative code moves it toward bit 0. The code comes either from an exponent input or from an immediate input.

Three operations are available: arithmetic shift, logical shift and normalize. A half-select decides whether the word enters the upper or the lower 16-bit half of a 32-bit field inside the 40-bit result. An OR-merge option combines the new shifted value with the result already held. Together these let a 32-bit value be shifted in two passes:

- The first pass shifts the high word with sign fill.
- The second pass shifts the low word with zero fill and ORs it into the result.

An overflow flag records lost significance. It is set when bits spill past the top of the result, or when the whole value drains out past bit 0. A request line qualifies every operation; when it is low, nothing changes.

Top module: `dual_field_shifter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` becomes zero and `ovf` becomes 0.
- R2: The effective code is the signed value of `imm_code` when `use_imm`=1, and of `exp_code` when `use_imm`=0. A code of zero or above shifts left by that many bits. A negative code shifts right by its magnitude.
- R3: The operation is selected by `op`: 0 is arithmetic, 1 is logical, 2 is normalize, and 3 behaves as arithmetic.
  - With `hi_sel`=1, the operand is placed at bits 31:16. It is sign-extended through bit 39 for arithmetic and normalize, and zero-extended for logical.
  - With `hi_sel`=0, the operand is placed at bits 15:0 and zero-extended in every operation.
- R4: Arithmetic and normalize fill vacated positions with zeros on left shifts. On right shifts they fill with bit 39 of the placed field.
- R5: Logical shifts fill vacated positions with zeros in both directions.
- R6: Bits moved above bit 39 or below bit 0 are discarded. A shift magnitude of 40 or more leaves only fill bits.
- R7: Normalize with `use_imm`=0 shifts by the negated value of `exp_code`, so a non-positive exponent gives a left shift. Normalize with `use_imm`=1 uses `imm_code` unchanged.
- R8: With `or_sel`=1 the new shifted value is bitwise-ORed into the current `result`. With `or_sel`=0 it replaces `result`.
- R9: While `req_valid` is low, `result` and `ovf` keep their values.
- R10: On a left shift, `ovf` is set if a discarded bit differs from the fill reference. The reference is the field's bit 39 for arithmetic and normalize, and 0 for logical. For arithmetic and normalize, `ovf` is also set if the new bit 39 differs from the field's bit 39.
- R11: On a right shift, `ovf` is set if the shifted value consists only of fill bits while the placed field did not.
- R12: `result` and `ovf` update on the rising edge at which `req_valid` is high. `ovf` describes the shifted value alone, not the OR-merged result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Condition enable; operation happens only when high |
| op | input | 2 | 0 arithmetic, 1 logical, 2 normalize, 3 as arithmetic |
| hi_sel | input | 1 | 1 places operand at bits 31:16, 0 at bits 15:0 |
| or_sel | input | 1 | 1 ORs the shifted value into the result |
| use_imm | input | 1 | 1 takes the code from imm_code, 0 from exp_code |
| exp_code | input | 8 | Signed exponent-register shift code |
| imm_code | input | 8 | Signed immediate shift code |
| operand | input | 16 | Two's-complement input word |
| result | output | 40 | Registered shift result |
| ovf | output | 1 | Registered overflow/underflow flag |

## Verification
Ten operand words are swept against every one of the 256 codes. The words are zero, one, both extremes, all-ones and several mixed patterns. Each is run for every operation, both halves and both code sources. The extremes and the mixed words separate sign fill from zero fill, and the codes beyond plus or minus 40 expose drain-out. Feeding a deliberately different value into the unused code input shows which source was taken. A two-pass 32-bit denormalization, and a pair of OR passes whose flags differ, check the merge. Cycles with the request low, issued with changed inputs, confirm that nothing moves.

// File: rtl/sr_pkg.sv
// Package: shared widths and operation codes for the bidirectional shifter.
// Assumes two's-complement operands and a result at least twice the operand width.
package sr_pkg;
    localparam int OPW   = 16;
    localparam int RESW  = 40;
    localparam int CODEW = 8;

    typedef enum logic [1:0] {
        OP_ARITH = 2'd0,
        OP_LOGIC = 2'd1,
        OP_NORM  = 2'd2,
        OP_ALT   = 2'd3
    } sr_op_e;
endpackage

// File: rtl/sr_field_place.sv
// Module: sr_field_place
// Places the operand in the upper or lower half of the 2*OPW field of a RESW result.
// Upper placement optionally sign-extends through the top bit. Lower placement always zero-extends.
// Assumes RESW > 2*OPW.
module sr_field_place #(
    parameter int OPW  = 16,
    parameter int RESW = 40
) (
    input  logic [OPW-1:0]  operand,
    input  logic            hi_sel,
    input  logic            sign_ext,
    output logic [RESW-1:0] field
);
    localparam int TOPW = RESW - 2*OPW;

    // Build the placed field from the half select and the extension mode
    always_comb begin
        if (hi_sel) begin
            field = {{TOPW{sign_ext & operand[OPW-1]}}, operand, {OPW{1'b0}}};
        end else begin
            field = {{(RESW-OPW){1'b0}}, operand};
        end
    end
endmodule

// File: rtl/sr_barrel.sv
// Module: sr_barrel
// Logarithmic barrel shifter. It moves data left or right by amt, inserting the fill bit.
// Stages whose step is at least W replace the whole word with fill.
// Assumes amt is an unsigned magnitude.
module sr_barrel #(
    parameter int W  = 40,
    parameter int AW = 8
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          to_left,
    input  logic          fill,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [0:AW];

    assign stg[0] = din;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam longint STEP = longint'(1) << k;
        if (STEP >= W) begin : g_flush
            // Step is past the word: the whole word becomes fill
            always_comb stg[k+1] = amt[k] ? {W{fill}} : stg[k];
        end else begin : g_move
            localparam int S = int'(STEP);
            // Conditionally move by 2^k in the chosen direction
            always_comb begin
                if (!amt[k]) begin
                    stg[k+1] = stg[k];
                end else if (to_left) begin
                    stg[k+1] = {stg[k][W-1-S:0], {S{fill}}};
                end else begin
                    stg[k+1] = {{S{fill}}, stg[k][W-1:S]};
                end
            end
        end
    end

    assign dout = stg[AW];
endmodule

// File: rtl/sr_flag_eval.sv
// Module: sr_flag_eval
// Derives the overflow/underflow flag from the placed field and the shifted value.
// Left shifts: the shifted value is moved back; any mismatch means a significant bit was lost.
// Right shifts: a result made only of fill bits from a field that was not means drain-out.
// Assumes the fill reference is field[W-1] for arithmetic and 0 for logical.
module sr_flag_eval #(
    parameter int W  = 40,
    parameter int AW = 8
) (
    input  logic [W-1:0]  field,
    input  logic [W-1:0]  shifted,
    input  logic [AW-1:0] amt,
    input  logic          to_left,
    input  logic          arith,
    output logic          flag
);
    logic [W-1:0] restored;
    logic         ref_bit;
    logic         back_fill;

    assign ref_bit   = arith & field[W-1];
    assign back_fill = arith & shifted[W-1];

    sr_barrel #(.W(W), .AW(AW)) u_back (
        .din     (shifted),
        .amt     (amt),
        .to_left (1'b0),
        .fill    (back_fill),
        .dout    (restored)
    );

    // Select the loss test matching the shift direction
    always_comb begin
        if (to_left) begin
            flag = (restored != field);
        end else begin
            flag = (shifted == {W{ref_bit}}) && (field != {W{ref_bit}});
        end
    end
endmodule

// File: rtl/dual_field_shifter.sv
// Module: dual_field_shifter (top)
// Bidirectional 16-to-40-bit shifter with a registered result and flag.
// Selects the code source, forms the signed amount (negated for exponent normalize),
// places the operand, shifts, evaluates the flag and optionally OR-merges.
// Assumes a synchronous active-low reset; req_valid qualifies every update.
module dual_field_shifter
    import sr_pkg::*;
#(
    parameter int OP_W   = OPW,
    parameter int RES_W  = RESW,
    parameter int CODE_W = CODEW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        op,
    input  logic              hi_sel,
    input  logic              or_sel,
    input  logic              use_imm,
    input  logic [CODE_W-1:0] exp_code,
    input  logic [CODE_W-1:0] imm_code,
    input  logic [OP_W-1:0]   operand,
    output logic [RES_W-1:0]  result,
    output logic              ovf
);
    localparam int EW = CODE_W + 1;

    sr_op_e            op_e;
    logic              is_arith;
    logic              negate;
    logic [CODE_W-1:0] code_raw;
    logic [EW-1:0]     code_ext;
    logic [EW-1:0]     eff;
    logic              to_left;
    logic [CODE_W-1:0] mag;
    logic [RES_W-1:0]  field;
    logic [RES_W-1:0]  shifted;
    logic              fwd_fill;
    logic              flag_next;

    assign op_e = sr_op_e'(op);

    // Decode operation class and code source
    always_comb begin
        is_arith = (op_e != OP_LOGIC);
        negate   = (op_e == OP_NORM) && !use_imm;
        code_raw = use_imm ? imm_code : exp_code;
        code_ext = {code_raw[CODE_W-1], code_raw};
    end

    // Form signed effective code, direction and magnitude
    always_comb begin
        eff     = negate ? ({EW{1'b0}} - code_ext) : code_ext;
        to_left = ~eff[EW-1];
        mag     = eff[EW-1] ? ({CODE_W{1'b0}} - eff[CODE_W-1:0]) : eff[CODE_W-1:0];
    end

    sr_field_place #(.OPW(OP_W), .RESW(RES_W)) u_place (
        .operand  (operand),
        .hi_sel   (hi_sel),
        .sign_ext (is_arith),
        .field    (field)
    );

    assign fwd_fill = (~to_left) & is_arith & field[RES_W-1];

    sr_barrel #(.W(RES_W), .AW(CODE_W)) u_shift (
        .din     (field),
        .amt     (mag),
        .to_left (to_left),
        .fill    (fwd_fill),
        .dout    (shifted)
    );

    sr_flag_eval #(.W(RES_W), .AW(CODE_W)) u_flag (
        .field   (field),
        .shifted (shifted),
        .amt     (mag),
        .to_left (to_left),
        .arith   (is_arith),
        .flag    (flag_next)
    );

    // Result and flag register: clear, hold, replace or OR-merge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            ovf    <= 1'b0;
        end else if (req_valid) begin
            result <= or_sel ? (result | shifted) : shifted;
            ovf    <= flag_next;
        end
    end
endmodule

// File: rtl/sr_checker.sv
// Module: sr_checker
// Temporal properties on the shifter ports, attached to the top module by bind.
module sr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  op,
    input logic        hi_sel,
    input logic        or_sel,
    input logic        use_imm,
    input logic [7:0]  exp_code,
    input logic [7:0]  imm_code,
    input logic [15:0] operand,
    input logic [39:0] result,
    input logic        ovf
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result == 40'd0 && !ovf));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(result) && $stable(ovf)));

    // R8
    or_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && or_sel) |=> ((result & $past(result)) == $past(result)));

    // R5
    logic_right_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !or_sel && op == 2'd1 && !hi_sel && use_imm && imm_code[7])
        |=> (result[39:16] == 24'd0));

    // R7
    norm_zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !or_sel && op == 2'd2 && !hi_sel && !use_imm && exp_code == 8'd0)
        |=> (result == {24'd0, $past(operand)} && !ovf));
endmodule

bind dual_field_shifter sr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .op        (op),
    .hi_sel    (hi_sel),
    .or_sel    (or_sel),
    .use_imm   (use_imm),
    .exp_code  (exp_code),
    .imm_code  (imm_code),
    .operand   (operand),
    .result    (result),
    .ovf       (ovf)
);

// File: tb/sim_dual_field_shifter.sv
module sim_dual_field_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        hi_sel = 1'b0;
    logic        or_sel = 1'b0;
    logic        use_imm = 1'b0;
    logic [7:0]  exp_code = 8'd0;
    logic [7:0]  imm_code = 8'd0;
    logic [15:0] operand = 16'd0;
    logic [39:0] result;
    logic        ovf;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    dual_field_shifter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
        .hi_sel(hi_sel), .or_sel(or_sel), .use_imm(use_imm),
        .exp_code(exp_code), .imm_code(imm_code), .operand(operand),
        .result(result), .ovf(ovf)
    );

    // Reference computed bit by bit from the requirements
    function automatic void model(input logic [1:0] mop, input logic mhi, input logic muse,
                                  input logic [7:0] ec, input logic [7:0] ic,
                                  input logic [15:0] d,
                                  output logic [39:0] r, output logic f);
        int c;
        int n;
        logic [39:0] fld;
        logic fb;
        bit ar;
        ar = (mop != 2'd1);
        c = muse ? int'($signed(ic)) : int'($signed(ec));
        if (mop == 2'd2 && !muse) c = -c;
        fld = '0;
        for (int i = 0; i < 16; i++) fld[mhi ? i + 16 : i] = d[i];
        if (mhi && ar) for (int i = 32; i < 40; i++) fld[i] = d[15];
        fb = ar ? fld[39] : 1'b0;
        f = 1'b0;
        if (c >= 0) begin
            n = c;
            for (int i = 0; i < 40; i++) r[i] = (i - n >= 0) ? fld[i - n] : 1'b0;
            for (int j = 0; j < 40; j++) begin
                if (ar && j >= 39 - n && fld[j] != fld[39]) f = 1'b1;
                if (!ar && j >= 40 - n && fld[j]) f = 1'b1;
            end
        end else begin
            n = -c;
            for (int i = 0; i < 40; i++) r[i] = (i + n <= 39) ? fld[i + n] : fb;
            f = (r == {40{fb}}) && (fld != {40{fb}});
        end
    endfunction

    task automatic check(input string req, input logic [39:0] er, input logic ef);
        total++;
        if (result !== er || ovf !== ef) begin
            bad++;
            $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b", req, result, ovf, er, ef);
        end
    endtask

    // Drive one request after a falling edge; sample at the next falling edge
    task automatic issue(input logic v, input logic [1:0] o, input logic h, input logic ors,
                         input logic ui, input logic [7:0] ec, input logic [7:0] ic,
                         input logic [15:0] d);
        req_valid = v; op = o; hi_sel = h; or_sel = ors; use_imm = ui;
        exp_code = ec; imm_code = ic; operand = d;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [10];
        logic [39:0] er;
        logic [39:0] prev;
        logic ef;
        string tag;
        pats = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF,
                 16'hB6A3, 16'h765D, 16'h4000, 16'h00F0, 16'hC000};
        repeat (3) @(negedge clk);
        check("R1 reset", 40'd0, 1'b0);
        rst_n = 1'b1;

        // Sweep: every code, both sources, both halves, all operations (R2..R7, R10..R12)
        for (int p = 0; p < 10; p++) begin
            for (int o = 0; o < 3; o++) begin
                for (int h = 0; h < 2; h++) begin
                    for (int u = 0; u < 2; u++) begin
                        for (int c = -128; c < 128; c++) begin
                            logic [7:0] cc;
                            logic [7:0] other;
                            cc = 8'(c);
                            other = cc ^ 8'h5A;
                            if (u == 1) issue(1'b1, 2'(o), h[0], 1'b0, 1'b1, other, cc, pats[p]);
                            else        issue(1'b1, 2'(o), h[0], 1'b0, 1'b0, cc, other, pats[p]);
                            if (u == 1) model(2'(o), h[0], 1'b1, other, cc, pats[p], er, ef);
                            else        model(2'(o), h[0], 1'b0, cc, other, pats[p], er, ef);
                            if (o == 2)      tag = "R7 normalize";
                            else if (o == 1) tag = "R5 logical R6 R10 R11";
                            else             tag = "R4 arithmetic R2 R3 R6 R10 R11";
                            check(tag, er, ef);
                        end
                    end
                end
            end
        end

        // Op 3 behaves as arithmetic (R3)
        issue(1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 8'd0, 8'hFD, 16'hB6A3);
        model(2'd0, 1'b1, 1'b1, 8'd0, 8'hFD, 16'hB6A3, er, ef);
        check("R3 op3", er, ef);

        // Two-pass 32-bit denormalization with OR merge (R8, R12)
        issue(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 8'hFD, 8'd0, 16'hB6A3);
        issue(1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 8'hFD, 8'd0, 16'h765D);
        er = 40'($signed({8'hFF, 32'hB6A3765D}) >>> 3);
        check("R8 two-pass denorm", er, 1'b0);

        // OR merge: flag comes from the new value only (R12)
        issue(1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 8'd0, 8'd4, 16'h00F0);
        prev = 40'h0000000F00;
        check("R8 base", prev, 1'b0);
        issue(1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 8'd0, 8'hF8, 16'h00F0);
        check("R12 or flag", prev, 1'b1);
        issue(1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 8'd0, 8'd0, 16'h1234);
        check("R8 or merge", prev | 40'h1234, 1'b0);

        // Request low: changed inputs have no effect (R9)
        issue(1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 8'd0, 8'd30, 16'h7FFF);
        model(2'd0, 1'b1, 1'b1, 8'd0, 8'd30, 16'h7FFF, er, ef);
        check("R10 setup", er, ef);
        for (int k = 0; k < 4; k++) begin
            issue(1'b0, 2'(k), k[0], k[1], 1'b1, 8'd0, 8'(k * 3), 16'h0001);
            check("R9 hold", er, ef);
        end

        // Mid-run reset (R1)
        rst_n = 1'b0;
        issue(1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 8'd0, 8'd1, 16'hFFFF);
        check("R1 reset mid-run", 40'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule